// File: doc/BRIEF.md
# Memory Self-Test Sequencer with Direct Access

This block runs built-in self-tests on a single-port buffer RAM and gives software a direct path into that RAM. A control write loads an enable bit, a three-bit test mode, an auto-increment bit and a RAM address. The same write can carry a start strobe. Two read-only flags, pass and fail, report the outcome of the last test.

The test modes are as follows. Two fill modes write a constant word to every location. Two read modes read every location back and compare it against all-zeros or all-ones. A pattern mode writes a word derived from each address and then reads the whole array back and checks it. In bypass mode a separate data port reads or writes the RAM location held in the address field, and that field can step forward after each access.

The block drives the RAM address, write data, write strobe and read strobe, and it compares the read data. The RAM sits outside the block and returns read data one cycle after a read strobe.

Top module: `mem_selftest`

## Requirements
- R1: After reset, pass reads 1, fail reads 0, auto-increment reads 1, enable reads 0, mode reads 000 and the address field reads 0.
- R2: A control write loads enable, mode, auto-increment and address only while no test is running. A start strobe takes effect only when the same write sets enable to 1. Control writes made while a test runs are ignored.
- R3: An accepted start in mode 001, 010, 011, 100 or 101 clears both pass and fail in the next cycle. When the test completes, exactly one of the two flags is set, and the pair is never 1 and 1 together.
- R4: Mode 010 writes 0x00000000 and mode 100 writes 0xFFFFFFFF to every address from 0 to 2^AW-1, one write per cycle. Each then finishes with pass set.
- R5: Mode 011 reads every address and expects all-zeros; mode 101 reads every address and expects all-ones. Any mismatching word ends the test with fail set. Otherwise the test ends with pass set.
- R6: Mode 001 writes pat(a) = ~a ^ (a << DW/2) to every address a, with a zero-extended to DW bits. It then reads every address back and ends with fail if any word differs from pat(a), and with pass otherwise.
- R7: An accepted start with mode 000 or 111 sets fail to 1 and pass to 0 in the next cycle, and it touches no RAM location.
- R8: In bypass mode (mode 110, enable 1, no test running), a data write stores the data-port word at the RAM location given by the address field.
- R9: In bypass mode, a data read presents the word stored at the address field on the data output two cycles after the read strobe. The data output holds that word until the next bypass read.
- R10: After each accepted bypass access, the address field advances by one, wrapping from 2^AW-1 to 0, when auto-increment is 1. It stays unchanged when auto-increment is 0.
- R11: When enable is 0 or the mode is not 110, data-port reads and writes have no effect: the RAM is not written, the address field is unchanged and the data output keeps its value.
- R12: A start strobe with enable 1 and mode 110 leaves pass and fail unchanged and runs no test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write |
| ctl_start | input | 1 | Start strobe carried by the control write |
| ctl_enable | input | 1 | Enable value to load |
| ctl_mode | input | 3 | Mode value to load |
| ctl_autoinc | input | 1 | Auto-increment value to load |
| ctl_addr | input | AW | Address value to load |
| dat_we | input | 1 | Data port write (bypass) |
| dat_re | input | 1 | Data port read (bypass) |
| dat_wdata | input | DW | Data port write word |
| dat_rdata | output | DW | Data port read word |
| cfg_enable | output | 1 | Current enable bit |
| cfg_mode | output | 3 | Current mode |
| cfg_autoinc | output | 1 | Current auto-increment bit |
| cfg_addr | output | AW | Current address field |
| bist_pass | output | 1 | Last test passed |
| bist_fail | output | 1 | Last test failed |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | DW | RAM write word |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_rdata | input | DW | RAM read word, valid one cycle after the read strobe |

## Verification
The assertions assume that the RAM returns, exactly one cycle after each read strobe, the word stored at the strobed address. They also assume that the host never asserts a data-port access in the same cycle as a control write, because the control write would take priority over the address step. The bench keeps to both assumptions. Its RAM model responds to every read strobe in the following cycle, and its tasks drive one host action per cycle. A bench-side stuck-bit switch and bypass-written words are the only way corrupted data reaches the comparator.

// File: rtl/mem_selftest.sv
module mem_selftest #(
  parameter int AW = 14,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          ctl_start,
  input  logic          ctl_enable,
  input  logic [2:0]    ctl_mode,
  input  logic          ctl_autoinc,
  input  logic [AW-1:0] ctl_addr,
  input  logic          dat_we,
  input  logic          dat_re,
  input  logic [DW-1:0] dat_wdata,
  output logic [DW-1:0] dat_rdata,
  output logic          cfg_enable,
  output logic [2:0]    cfg_mode,
  output logic          cfg_autoinc,
  output logic [AW-1:0] cfg_addr,
  output logic          bist_pass,
  output logic          bist_fail,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_we,
  output logic          ram_re,
  input  logic [DW-1:0] ram_rdata
);
  localparam logic [AW-1:0] LAST = '1;
  localparam logic [2:0] M_PAT = 3'b001, M_RD0 = 3'b011, M_FL1 = 3'b100,
                         M_RD1 = 3'b101, M_BYP = 3'b110;

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_TAIL} st_t;
  st_t           st;
  logic [AW-1:0] idx;
  logic          chk_vld, err, rd_pend;
  logic [DW-1:0] chk_exp;

  function automatic logic [DW-1:0] word_for(input logic [2:0] m, input logic [AW-1:0] a);
    logic [DW-1:0] x;
    x = DW'(a);
    if (m == M_PAT) return ~x ^ (x << (DW/2));
    if (m == M_FL1 || m == M_RD1) return '1;
    return '0;
  endfunction

  wire busy    = (st != S_IDLE);
  wire go      = ctl_we && !busy && ctl_start && ctl_enable;
  wire rsv     = (ctl_mode == 3'b000) || (ctl_mode == 3'b111);
  wire go_rsv  = go && rsv;
  wire go_run  = go && !rsv && (ctl_mode != M_BYP);
  wire byp     = !busy && cfg_enable && (cfg_mode == M_BYP);
  wire byp_wr  = byp && dat_we;
  wire byp_rd  = byp && dat_re && !dat_we;
  wire mism    = chk_vld && (ram_rdata != chk_exp);

  assign ram_we    = (st == S_WR) || byp_wr;
  assign ram_re    = (st == S_RD) || byp_rd;
  assign ram_addr  = busy ? idx : cfg_addr;
  assign ram_wdata = busy ? word_for(cfg_mode, idx) : dat_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      idx         <= '0;
      chk_vld     <= 1'b0;
      chk_exp     <= '0;
      err         <= 1'b0;
      rd_pend     <= 1'b0;
      dat_rdata   <= '0;
      cfg_enable  <= 1'b0;
      cfg_mode    <= 3'b000;
      cfg_autoinc <= 1'b1;
      cfg_addr    <= '0;
      bist_pass   <= 1'b1;
      bist_fail   <= 1'b0;
    end else begin
      rd_pend <= byp_rd;
      if (rd_pend) dat_rdata <= ram_rdata;

      if (ctl_we && !busy) begin
        cfg_enable  <= ctl_enable;
        cfg_mode    <= ctl_mode;
        cfg_autoinc <= ctl_autoinc;
        cfg_addr    <= ctl_addr;
      end else if ((byp_wr || byp_rd) && cfg_autoinc) begin
        cfg_addr <= cfg_addr + 1'b1;
      end

      if (go_rsv) begin
        bist_pass <= 1'b0;
        bist_fail <= 1'b1;
      end
      if (go_run) begin
        bist_pass <= 1'b0;
        bist_fail <= 1'b0;
        err       <= 1'b0;
        idx       <= '0;
        st        <= (ctl_mode == M_RD0 || ctl_mode == M_RD1) ? S_RD : S_WR;
      end

      chk_vld <= 1'b0;
      if (mism) err <= 1'b1;

      case (st)
        S_WR: begin
          idx <= idx + 1'b1;
          if (idx == LAST) begin
            if (cfg_mode == M_PAT) st <= S_RD;
            else begin
              st        <= S_IDLE;
              bist_pass <= 1'b1;
            end
          end
        end
        S_RD: begin
          idx     <= idx + 1'b1;
          chk_vld <= 1'b1;
          chk_exp <= word_for(cfg_mode, idx);
          if (idx == LAST) st <= S_TAIL;
        end
        S_TAIL: begin
          st        <= S_IDLE;
          bist_pass <= !(err || mism);
          bist_fail <= err || mism;
        end
        default: ;
      endcase
    end
  end

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bist_pass && bist_fail)); // R3
  AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    go_run |=> (!bist_pass && !bist_fail)); // R3
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TAIL) |=> (bist_pass ^ bist_fail)); // R3
  AST_RSV_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    go_rsv |=> (bist_fail && !bist_pass && !ram_we && !ram_re)); // R7
  AST_AUTOINC: assert property (@(posedge clk) disable iff (!rst_n)
    ((byp_wr || byp_rd) && cfg_autoinc && !ctl_we) |=> (cfg_addr == AW'($past(cfg_addr) + 1'b1))); // R10
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && !byp_wr && !byp_rd && !busy) |=> $stable(cfg_addr)); // R11
  AST_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cfg_enable && cfg_mode == M_BYP)) |-> (!ram_we && !ram_re)); // R11
  AST_RAM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_re)); // R8
endmodule

// File: tb/mem_selftest_tb.sv
module mem_selftest_tb;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          ctl_we = 0, ctl_start = 0, ctl_enable = 0, ctl_autoinc = 0;
  logic [2:0]    ctl_mode = 0;
  logic [AW-1:0] ctl_addr = 0;
  logic          dat_we = 0, dat_re = 0;
  logic [DW-1:0] dat_wdata = 0, dat_rdata;
  logic          cfg_enable, cfg_autoinc, bist_pass, bist_fail;
  logic [2:0]    cfg_mode;
  logic [AW-1:0] cfg_addr, ram_addr;
  logic [DW-1:0] ram_wdata, ram_rdata;
  logic          ram_we, ram_re;

  mem_selftest #(.AW(AW), .DW(DW)) u_dut (.*);

  logic [DW-1:0] mem [N];
  logic [DW-1:0] snap [N];
  logic stuck = 1'b0;
  wire [DW-1:0] wd = (stuck && ram_addr == AW'(17)) ? (ram_wdata & ~32'h8) : ram_wdata;
  always_ff @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= wd;
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  int total = 0, bad = 0;

  function automatic logic [DW-1:0] pat(input int a);
    logic [DW-1:0] x;
    x = DW'(a);
    return ~x ^ (x << 16);
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic st, input logic en, input logic [2:0] m, input logic ai, input int a);
    @(negedge clk);
    ctl_we = 1; ctl_start = st; ctl_enable = en; ctl_mode = m; ctl_autoinc = ai; ctl_addr = AW'(a);
    @(negedge clk);
    ctl_we = 0; ctl_start = 0;
  endtask

  task automatic bwr(input logic [DW-1:0] d);
    @(negedge clk); dat_we = 1; dat_wdata = d;
    @(negedge clk); dat_we = 0;
  endtask

  task automatic brd(output logic [DW-1:0] d);
    @(negedge clk); dat_re = 1;
    @(negedge clk); dat_re = 0;
    @(negedge clk); d = dat_rdata;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!(bist_pass || bist_fail) && n < 1000) begin @(negedge clk); n++; end
    if (n >= 1000) check({req, " timeout"}, 0, 1);
  endtask

  task automatic run(input logic [2:0] m, input logic expect_pass, input string req);
    ctl(1, 1, m, 1, 0);
    check({req, " flags cleared at start (R3)"}, {30'd0, bist_pass, bist_fail}, 0);
    wait_done(req);
    check({req, " outcome"}, {30'd0, bist_pass, bist_fail}, {30'd0, expect_pass, !expect_pass});
  endtask

  task automatic mem_all(input logic [2:0] kind, input string req);
    int errs = 0;
    for (int a = 0; a < N; a++) begin
      logic [DW-1:0] e;
      e = (kind == 3'b001) ? pat(a) : (kind == 3'b100) ? '1 : '0;
      if (mem[a] !== e) errs++;
    end
    check({req, " RAM contents mismatches"}, errs, 0);
  endtask

  task automatic take_snap();
    for (int a = 0; a < N; a++) snap[a] = mem[a];
  endtask

  task automatic cmp_snap(input string req);
    int errs = 0;
    for (int a = 0; a < N; a++) if (mem[a] !== snap[a]) errs++;
    check({req, " RAM untouched"}, errs, 0);
  endtask

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset flags/cfg",
          {17'd0, bist_pass, bist_fail, cfg_autoinc, cfg_enable, cfg_mode, 3'd0, cfg_addr},
          {17'd0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, 3'd0, 6'd0});

    run(3'b010, 1, "R4 fill zeros");  mem_all(3'b010, "R4 fill zeros");
    run(3'b011, 1, "R5 read zeros ok");
    run(3'b100, 1, "R4 fill ones");   mem_all(3'b100, "R4 fill ones");
    run(3'b101, 1, "R5 read ones ok");
    run(3'b011, 0, "R5 read zeros on ones");
    run(3'b001, 1, "R6 pattern ok");  mem_all(3'b001, "R6 pattern");

    stuck = 1;
    run(3'b001, 0, "R6 pattern with stuck bit");
    stuck = 0;

    run(3'b100, 1, "R4 refill ones");
    ctl(0, 1, 3'b110, 0, 40);
    bwr(32'hFFFF_FFFE);
    run(3'b101, 0, "R5 read ones with one bad word");

    take_snap();
    ctl(1, 1, 3'b000, 1, 0);
    check("R7 mode 000 flags", {30'd0, bist_pass, bist_fail}, 32'd1);
    ctl(1, 1, 3'b111, 1, 0);
    check("R7 mode 111 flags", {30'd0, bist_pass, bist_fail}, 32'd1);
    repeat (3) @(negedge clk);
    cmp_snap("R7");

    ctl(0, 1, 3'b110, 1, 60);
    for (int k = 0; k < 8; k++) bwr(32'hA5000000 + DW'(k));
    check("R10 address wrapped after 8 accesses", DW'(cfg_addr), 4);
    for (int k = 0; k < 8; k++)
      check("R8 bypass write", mem[(60 + k) % N], 32'hA5000000 + DW'(k));

    ctl(0, 1, 3'b110, 0, 62);
    brd(d);
    check("R9 bypass read", d, 32'hA5000002);
    check("R10 no step with auto-increment off", DW'(cfg_addr), 62);
    brd(d);
    check("R9 repeated read same word", d, 32'hA5000002);
    ctl(0, 1, 3'b110, 1, 1);
    brd(d);
    check("R9 read with step", d, 32'hA5000005);
    check("R10 step after read", DW'(cfg_addr), 2);

    take_snap();
    ctl(0, 0, 3'b110, 1, 10);
    bwr(32'h1234_5678);
    brd(d);
    check("R11 disabled read keeps data output", d, 32'hA5000005);
    check("R11 disabled address unchanged", DW'(cfg_addr), 10);
    ctl(0, 1, 3'b010, 1, 11);
    bwr(32'h1234_5678);
    check("R11 non-bypass address unchanged", DW'(cfg_addr), 11);
    cmp_snap("R11");

    run(3'b010, 1, "R12 prep");
    ctl(1, 1, 3'b000, 1, 0);
    take_snap();
    ctl(1, 1, 3'b110, 1, 0);
    repeat (3) @(negedge clk);
    check("R12 bypass start flags unchanged", {30'd0, bist_pass, bist_fail}, 32'd1);
    cmp_snap("R12");

    ctl(1, 0, 3'b100, 1, 0);
    repeat (3) @(negedge clk);
    check("R2 start without enable ignored", {30'd0, bist_pass, bist_fail}, 32'd1);
    cmp_snap("R2");
    ctl(1, 1, 3'b100, 1, 0);
    ctl(0, 1, 3'b011, 0, 33);
    check("R2 write during test ignored", {26'd0, cfg_mode, cfg_addr}, {26'd0, 3'b100, 6'd0});
    wait_done("R2 busy test");
    check("R2 started test completed", {30'd0, bist_pass, bist_fail}, 32'd2);
    mem_all(3'b100, "R2 fill ones");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule